// File: doc/BRIEF.md
# UART Sleep and Low-Power Controller

This block decides when a multi-channel UART may stop its UART clock and its baud-rate clock, and when those clocks must run again. It runs on a free-running clock that is never gated. Each cycle it looks at every channel's FIFO and shift-register empty flags, its interrupt-pending flag, its modem inputs and its RX serial line. It drops `clk_en` only when sleep is armed and every channel is quiet at the same time.

A start bit on an RX line, a write into a TX FIFO, or any change on a modem input wakes the block for at least one cycle. Once the channels are quiet again, the block goes back to sleep without any help from software.

Each channel has an RX idle timer measured in character times. A channel can set a bypass bit so that its RX line plays no part in sleep entry. A separate low-power pin overrides everything else. While that pin is high the clocks stop and host-pin isolation is asserted.

Top module: `slp_power_ctrl`

## Requirements
- R1: Sleep is armed only when `enh_en` is 1 and every bit of `slp_en` is 1. While it is not armed, the block never enters sleep.
- R2: Sleep is entered only when all of the following hold on every channel: TX FIFO and shift register empty, RX FIFO empty, no interrupt pending, and no modem input changed since the previous cycle.
- R3: With `rx_bypass` 0, a channel's RX line must have been high for 4 character times before sleep. Any low level restarts that count. With `rx_bypass` 1, the RX line has no effect on entry.
- R4: A character time is (7 + `wlen` + `par_en` + `stop2`) bit times, where `wlen` 0..3 means 5..8 data bits. A bit time is TICKS_PER_BIT `baud_tick` pulses. Ticks count only while the block is awake.
- R5: `clk_en` is 1 in the awake mode and 0 in the sleep and low-power modes. It changes only in the cycle after the mode register changes.
- R6: From sleep, the block returns to awake in the next cycle on any of these: a 1-to-0 edge on an RX line, a `tx_wr` pulse, or a change on any modem input.
- R7: After a wake-up, the block re-enters sleep by itself as soon as R1 to R3 hold again and no wake event is present.
- R8: Clearing `slp_en` on any single channel disarms the whole block. A sleeping block returns to awake in the next cycle.
- R9: While `lp_pin` is 1, the next mode is low-power, whatever the mode was before. In low-power, `iso_en` is 1 and `clk_en` is 0. The first cycle with `lp_pin` 0 leads to awake.
- R10: `pm_mode` encodes awake as 0, sleep as 1 and low-power as 2. Reset leaves the block awake, with `clk_en` 1 and `iso_en` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enh_en | input | 1 | Enhanced-functions enable |
| slp_en | input | NUM_CH | Per-channel sleep-enable bits |
| rx_bypass | input | NUM_CH | 1: ignore the RX line for sleep entry |
| wlen | input | 2*NUM_CH | Data length code per channel (0..3 = 5..8 bits) |
| par_en | input | NUM_CH | Parity bit present, per channel |
| stop2 | input | NUM_CH | Second stop bit present, per channel |
| baud_tick | input | 1 | Baud tick from the baud generator |
| tx_empty | input | NUM_CH | TX FIFO and TX shift register both empty |
| rx_empty | input | NUM_CH | RX FIFO empty |
| irq_pend | input | NUM_CH | Interrupt pending |
| modem_in | input | NUM_CH*MODEM_W | Modem input lines |
| rx_in | input | NUM_CH | RX serial lines (idle high) |
| tx_wr | input | NUM_CH | TX FIFO write strobe |
| lp_pin | input | 1 | Hard low-power request |
| clk_en | output | 1 | Enable for the UART and baud clocks |
| iso_en | output | 1 | Host-pin isolation enable |
| pm_mode | output | 2 | Current mode (0 awake, 1 sleep, 2 low-power) |

## Verification
The assertions assume the following about the inputs:
- `modem_in` is 0 when reset is released, so a modem change is never reported before the first clock.
- `rx_in` is high at that moment.
- Every input is stable across each rising edge.

The bench drives all inputs just after the falling edge and holds them through reset at the idle levels. Its random phase keeps RX low pulses, TX writes, modem toggles and low-power requests rare. This lets the idle timers reach their thresholds and gives sleep entries, wake-ups and re-entries many chances to happen.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        PM_AWAKE  = 2'd0,
        PM_SLEEP  = 2'd1,
        PM_LOWPWR = 2'd2
    } pm_mode_e;

    // Four character times in baud ticks; a character is start + data + parity + stop bits.
    function automatic int unsigned idle_ticks(input logic [1:0] wl, input logic par,
                                               input logic st2, input int unsigned tpb);
        int unsigned bits;
        bits = 32'd7 + 32'(wl) + 32'(par) + 32'(st2);
        return 32'd4 * tpb * bits;
    endfunction

endpackage

// File: rtl/slp_idle_timer.sv
module slp_idle_timer
    import slp_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int CW            = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_in,
    input  logic       tick_en,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       stop2,
    output logic       idle_ok
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t          tmr_d, tmr_q;
    logic [CW-1:0] thr;

    assign thr     = CW'(idle_ticks(wlen, par_en, stop2, 32'(TICKS_PER_BIT)));
    assign idle_ok = (tmr_q.cnt >= thr);

    always_comb begin
        tmr_d = tmr_q;
        if (!rx_in) begin
            tmr_d.cnt = '0;
        end else if (tick_en && !idle_ok) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R3: a low RX level restarts the idle count
    p_rx_low_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_in |=> !idle_ok);

    // R4: without a tick the count holds
    p_no_tick_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in && !tick_en) |=> $stable(tmr_q.cnt));

endmodule

// File: rtl/slp_wake_detect.sv
module slp_wake_detect #(
    parameter int NUM_CH  = 2,
    parameter int MODEM_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         rx_in,
    input  logic [NUM_CH*MODEM_W-1:0] modem_in,
    input  logic [NUM_CH-1:0]         tx_wr,
    output logic                      modem_chg,
    output logic                      wake
);

    typedef struct packed {
        logic [NUM_CH-1:0]         rx;
        logic [NUM_CH*MODEM_W-1:0] modem;
    } wd_t;

    wd_t  wd_d, wd_q;
    logic rx_fall;

    always_comb begin
        wd_d.rx    = rx_in;
        wd_d.modem = modem_in;
    end

    assign rx_fall   = |(wd_q.rx & ~rx_in);
    assign modem_chg = (wd_q.modem != modem_in);
    assign wake      = rx_fall | modem_chg | (|tx_wr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q.rx    <= '1;
            wd_q.modem <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    // R6: a TX FIFO write is always reported as a wake event
    p_txwr_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_wr) |-> wake);

endmodule

// File: rtl/slp_power_ctrl.sv
module slp_power_ctrl
    import slp_pkg::*;
#(
    parameter int NUM_CH        = 2,
    parameter int MODEM_W       = 4,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enh_en,
    input  logic [NUM_CH-1:0]         slp_en,
    input  logic [NUM_CH-1:0]         rx_bypass,
    input  logic [2*NUM_CH-1:0]       wlen,
    input  logic [NUM_CH-1:0]         par_en,
    input  logic [NUM_CH-1:0]         stop2,
    input  logic                      baud_tick,
    input  logic [NUM_CH-1:0]         tx_empty,
    input  logic [NUM_CH-1:0]         rx_empty,
    input  logic [NUM_CH-1:0]         irq_pend,
    input  logic [NUM_CH*MODEM_W-1:0] modem_in,
    input  logic [NUM_CH-1:0]         rx_in,
    input  logic [NUM_CH-1:0]         tx_wr,
    input  logic                      lp_pin,
    output logic                      clk_en,
    output logic                      iso_en,
    output logic [1:0]                pm_mode
);

    localparam int CW = $clog2(4 * 12 * TICKS_PER_BIT + 1);

    typedef struct packed {
        pm_mode_e mode;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic [NUM_CH-1:0] idle_ok;
    logic              tick_en, modem_chg, wake, armed, quiet;

    assign tick_en = baud_tick & (ctl_q.mode == PM_AWAKE);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        slp_idle_timer #(
            .TICKS_PER_BIT(TICKS_PER_BIT),
            .CW           (CW)
        ) tmr_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .rx_in  (rx_in[c]),
            .tick_en(tick_en),
            .wlen   (wlen[2*c +: 2]),
            .par_en (par_en[c]),
            .stop2  (stop2[c]),
            .idle_ok(idle_ok[c])
        );
    end

    slp_wake_detect #(
        .NUM_CH (NUM_CH),
        .MODEM_W(MODEM_W)
    ) wd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_in    (rx_in),
        .modem_in (modem_in),
        .tx_wr    (tx_wr),
        .modem_chg(modem_chg),
        .wake     (wake)
    );

    assign armed = enh_en & (&slp_en);
    assign quiet = (&tx_empty) & (&rx_empty) & ~(|irq_pend) & ~modem_chg
                 & (&(rx_bypass | idle_ok));

    always_comb begin
        ctl_d = ctl_q;
        if (lp_pin) begin
            ctl_d.mode = PM_LOWPWR;
        end else begin
            unique case (ctl_q.mode)
                PM_AWAKE:  if (armed && quiet && !wake) ctl_d.mode = PM_SLEEP;
                PM_SLEEP:  if (!armed || wake)          ctl_d.mode = PM_AWAKE;
                default:                                ctl_d.mode = PM_AWAKE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q.mode <= PM_AWAKE;
        else        ctl_q      <= ctl_d;
    end

    assign pm_mode = ctl_q.mode;
    assign clk_en  = (ctl_q.mode == PM_AWAKE);
    assign iso_en  = (ctl_q.mode == PM_LOWPWR);

    // R1: never sleep while disarmed
    p_disarmed_no_sleep_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !lp_pin) |=> (pm_mode != PM_SLEEP));

    // R2: a non-empty RX FIFO keeps an awake block awake
    p_rx_data_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == PM_AWAKE && !(&rx_empty) && !lp_pin) |=> (pm_mode == PM_AWAKE));

    // R6: a wake event ends sleep
    p_wake_exits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == PM_SLEEP && wake && !lp_pin) |=> (pm_mode == PM_AWAKE && clk_en));

    // R9: low-power pin override and release
    p_lp_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lp_pin |=> (pm_mode == PM_LOWPWR && iso_en && !clk_en));
    p_lp_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == PM_LOWPWR && !lp_pin) |=> (pm_mode == PM_AWAKE));

endmodule

// File: tb/slp_power_ctrl_tb.sv
module slp_power_ctrl_tb_top;

    localparam int NCH = 2;
    localparam int MW  = 4;
    localparam int TPB = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enh_en = 1'b0;
    logic [NCH-1:0]    slp_en = '0, rx_bypass = '0, par_en = '0, stop2 = '0;
    logic [2*NCH-1:0]  wlen = '0;
    logic              baud_tick = 1'b1;
    logic [NCH-1:0]    tx_empty = '1, rx_empty = '1, irq_pend = '0, rx_in = '1, tx_wr = '0;
    logic [NCH*MW-1:0] modem_in = '0;
    logic              lp_pin = 1'b0;
    logic              clk_en, iso_en;
    logic [1:0]        pm_mode;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // model state
    int             m_mode;
    int             m_cnt [NCH];
    logic [NCH-1:0] m_rx_prev;
    logic [NCH*MW-1:0] m_modem_prev;

    always #10 clk = ~clk;

    slp_power_ctrl #(.NUM_CH(NCH), .MODEM_W(MW), .TICKS_PER_BIT(TPB)) dut_i (
        .clk(clk), .rst_n(rst_n), .enh_en(enh_en), .slp_en(slp_en), .rx_bypass(rx_bypass),
        .wlen(wlen), .par_en(par_en), .stop2(stop2), .baud_tick(baud_tick),
        .tx_empty(tx_empty), .rx_empty(rx_empty), .irq_pend(irq_pend), .modem_in(modem_in),
        .rx_in(rx_in), .tx_wr(tx_wr), .lp_pin(lp_pin),
        .clk_en(clk_en), .iso_en(iso_en), .pm_mode(pm_mode));

    function automatic int exp_thr(input int c);
        int bits;
        bits = 1 + (5 + int'(wlen[2*c +: 2])) + int'(par_en[c]) + 1 + int'(stop2[c]);
        return 4 * bits * TPB;
    endfunction

    function automatic bit exp_quiet();
        bit q;
        q = (tx_empty == '1) && (rx_empty == '1) && (irq_pend == '0) && (modem_in == m_modem_prev);
        for (int c = 0; c < NCH; c++)
            if (!rx_bypass[c] && m_cnt[c] < exp_thr(c)) q = 0;
        return q;
    endfunction

    task automatic model_step();
        bit wk, arm;
        int nm;
        wk  = ((m_rx_prev & ~rx_in) != '0) || (tx_wr != '0) || (modem_in != m_modem_prev);
        arm = enh_en && (slp_en == '1);
        nm  = m_mode;
        if (lp_pin) nm = 2;
        else if (m_mode == 0) begin if (arm && exp_quiet() && !wk) nm = 1; end
        else if (m_mode == 1) begin if (!arm || wk) nm = 0; end
        else nm = 0;
        for (int c = 0; c < NCH; c++) begin
            if (!rx_in[c]) m_cnt[c] = 0;
            else if (baud_tick && m_mode == 0 && m_cnt[c] < exp_thr(c)) m_cnt[c]++;
        end
        m_rx_prev    = rx_in;
        m_modem_prev = modem_in;
        m_mode       = nm;
    endtask

    task automatic check(input string tag);
        n_tests++;
        if (pm_mode !== 2'(m_mode) || clk_en !== (m_mode == 0) || iso_en !== (m_mode == 2)) begin
            n_fail++;
            $display("FAIL %s: mode=%0d clk_en=%0b iso_en=%0b expected mode=%0d clk_en=%0b iso_en=%0b",
                     tag, pm_mode, clk_en, iso_en, m_mode, m_mode == 0, m_mode == 2);
        end
    endtask

    task automatic cyc(input string tag, input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            check(tag);
            tx_wr = '0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not end, expected end before 300000 cycles");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        m_mode = 0; m_rx_prev = '1; m_modem_prev = '0;
        for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R10");                             // reset state
        // R1: not armed without enh_en or with one slp_en bit clear
        rx_bypass = '1; slp_en = '1;
        cyc("R1", 20);
        enh_en = 1'b1; slp_en = 2'b01;
        cyc("R1", 20);
        // enter sleep with bypass, clocks stop
        slp_en = '1;
        cyc("R5", 3);
        // R6 wake by TX write, R7 automatic return
        tx_wr = 2'b10;
        cyc("R6");
        cyc("R7", 3);
        // R6 wake by modem change
        modem_in[5] = 1'b1;
        cyc("R6");
        cyc("R7", 3);
        // R6 start bit wakes; with bypass R3 the low RX line does not block re-entry
        rx_in[0] = 1'b0;
        cyc("R6");
        cyc("R3", 5);
        rx_in[0] = 1'b1;
        cyc("R3", 2);
        // R2 blockers
        rx_empty[1] = 1'b0; tx_wr = 2'b01;
        cyc("R2", 10);
        rx_empty[1] = 1'b1; irq_pend[0] = 1'b1;
        cyc("R2", 10);
        irq_pend[0] = 1'b0; tx_empty[0] = 1'b0;
        cyc("R2", 10);
        tx_empty[0] = 1'b1;
        cyc("R2", 3);
        // R8: clear one channel's enable while asleep
        slp_en = 2'b10;
        cyc("R8", 5);
        slp_en = '1;
        cyc("R8", 3);
        // R3/R4: idle timer with varying frame formats and tick gaps
        rx_bypass = 2'b00; wlen = 4'b0011; par_en = 2'b01; stop2 = 2'b10;
        tx_wr = 2'b01;
        cyc("R4", 100);
        baud_tick = 1'b0;
        cyc("R4", 300);
        baud_tick = 1'b1;
        cyc("R4", 700);
        rx_in[1] = 1'b0;
        cyc("R3", 3);
        rx_in[1] = 1'b1;
        cyc("R3", 800);
        // R9 low-power override from sleep and release
        lp_pin = 1'b1;
        cyc("R9", 5);
        lp_pin = 1'b0;
        cyc("R9", 3);
        // random phase
        for (int i = 0; i < 40000; i++) begin
            if ($urandom_range(0, 499) == 0) rx_in[$urandom_range(0, NCH-1)] ^= 1'b1;
            else if (rx_in != '1 && $urandom_range(0, 19) == 0) rx_in = '1;
            if ($urandom_range(0, 399) == 0) tx_wr = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 599) == 0) modem_in[$urandom_range(0, NCH*MW-1)] ^= 1'b1;
            irq_pend  = ($urandom_range(0, 299) == 0) ? 2'b01 : 2'b00;
            rx_empty  = ($urandom_range(0, 299) == 0) ? 2'b10 : 2'b11;
            tx_empty  = ($urandom_range(0, 299) == 0) ? 2'b01 : 2'b11;
            baud_tick = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 999) == 0) slp_en = 2'($urandom_range(0, 3));
            if (slp_en != '1 && $urandom_range(0, 49) == 0) slp_en = '1;
            if ($urandom_range(0, 1999) == 0) lp_pin = 1'b1;
            else if (lp_pin && $urandom_range(0, 9) == 0) lp_pin = 1'b0;
            if ($urandom_range(0, 2999) == 0) begin
                rx_bypass = 2'($urandom_range(0, 3));
                wlen = 4'($urandom_range(0, 15));
                par_en = 2'($urandom_range(0, 3));
                stop2 = 2'($urandom_range(0, 3));
            end
            cyc("R7");
        end
        finish_run();
    end

endmodule